// File: doc/BRIEF.md
# External and Low-Level Interrupt Front End

This block collects interrupt requests from a set of external request pins and from a whole-port low-level detector. It turns them into one prioritized vector request for a processor core. Each external pin has a 2-bit sense field that selects level, any-change, falling-edge or rising-edge triggering. It also has an enable bit and a sticky flag. Software clears a flag by writing a one to it, and the flag also clears when the core acknowledges that pin's vector. A separate enable lets any low pin on an 8-bit port raise its own request.

A global interrupt enable gates every request. It is cleared when the core acknowledges any vector and set again by a return-from-interrupt pulse. Pin inputs are expected to be synchronized to `clk` already. The core, the vector fetch and the pads lie outside the block.

Top module: `ext_irq_front`

## Requirements
- R1: Sense field of pin i is `sense_cfg[2i+1:2i]`: 00 low level, 01 any change, 10 falling edge, 11 rising edge. An edge is the difference between the pin value at one clock edge and its value at the previous clock edge. No edge is recognised at the first clock edge after reset is released.
- R2: A recognised edge sets the pin's flag, visible on `flags_o[i]` after that clock edge. The flag then holds until it is cleared. In level mode no flag is ever set.
- R3: External source i requests only when its pending condition, `ext_en[i]` and the global enable are all 1. Pending means the flag is 1, or level mode with the pin low.
- R4: A flag clears at the clock edge where `flag_clr[i]` is 1, or where `ack_valid` is 1 with `ack_vec` equal to i+1. If a recognised edge falls in the same cycle, the edge wins and the flag stays set.
- R5: With `lvl_en` and the global enable at 1, any 0 on `port_pins` requests vector NUM_EXT+1 (3 by default) in the same cycle, with no flag.
- R6: External source i uses vector i+1. While `req_valid` is 0, `req_vec` is 0.
- R7: The global enable `gie_o` is 0 after reset. It is 0 after any clock edge with `ack_valid`, and 1 after a clock edge with `irq_return` and no `ack_valid`.
- R8: When several sources request together, the lowest vector number is presented.
- R9: A level-mode request follows the pin in the same cycle: it is asserted while the pin is low and enabled, and dropped once the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | NUM_EXT | Synchronized external request pins |
| port_pins | input | PORT_W | Synchronized port watched by the low-level detector |
| sense_cfg | input | 2*NUM_EXT | Sense field per external pin |
| ext_en | input | NUM_EXT | Per-pin request enable |
| lvl_en | input | 1 | Low-level detector enable |
| flag_clr | input | NUM_EXT | Write-one-to-clear strobe per flag |
| irq_return | input | 1 | Return-from-interrupt pulse, sets the global enable |
| ack_valid | input | 1 | Core takes the vector on `ack_vec` |
| ack_vec | input | VEC_W | Vector being served |
| req_valid | output | 1 | A request is pending |
| req_vec | output | VEC_W | Winning vector number |
| flags_o | output | NUM_EXT | Sticky flags |
| gie_o | output | 1 | Global interrupt enable |

## Verification
Flags and the global enable are registered. The effect of an edge, a clear strobe, an acknowledge or a return therefore shows one clock edge after the cycle that carries it. The request outputs are combinational from the current inputs and the registered state, so a level-mode pin or a low port bit shows in the same cycle. The bench drives inputs just after the falling clock edge and samples all outputs 1 ns later. It then lets the rising edge pass and advances its own model with the inputs that were held over that edge. Every output is therefore compared in the cycle its value is due.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   typedef enum logic [1:0] {
      SENSE_LEVEL  = 2'b00,
      SENSE_TOGGLE = 2'b01,
      SENSE_FALL   = 2'b10,
      SENSE_RISE   = 2'b11
   } sense_e;

   // edge qualification for one pin given its previous and present sample
   function automatic logic edge_hit(sense_e mode, logic prv, logic cur);
      logic hit;
      unique case (mode)
         SENSE_TOGGLE: hit = prv ^ cur;
         SENSE_FALL:   hit = prv & ~cur;
         SENSE_RISE:   hit = ~prv & cur;
         default:      hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/eirq_sense_cell.sv
module eirq_sense_cell
   import eirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] sense,
   input  logic       clr_i,
   output logic       flag_o,
   output logic       pend_o
);

   logic   prev_q;
   logic   primed_q;
   logic   flag_q;
   logic   hit;
   sense_e mode;

   assign mode = sense_e'(sense);
   assign hit  = primed_q & edge_hit(mode, prev_q, pin);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         primed_q <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         prev_q   <= pin;
         primed_q <= 1'b1;
         if (hit)        flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;
   assign pend_o = flag_q | ((mode == SENSE_LEVEL) & ~pin);

endmodule

// File: rtl/eirq_lowlevel_det.sv
module eirq_lowlevel_det #(
   parameter int unsigned PORT_W  = 8,
   parameter bit          ENABLED = 1'b1
) (
   input  logic [PORT_W-1:0] port_pins,
   input  logic              lvl_en,
   output logic              pend_o
);

   generate
      if (ENABLED) begin : g_det
         assign pend_o = lvl_en & ~(&port_pins);
      end else begin : g_none
         logic unused_inputs;
         assign unused_inputs = lvl_en ^ (^port_pins);
         assign pend_o        = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/eirq_prio_enc.sv
module eirq_prio_enc #(
   parameter int unsigned NSRC  = 3,
   parameter int unsigned VEC_W = 2
) (
   input  logic [NSRC-1:0]  src_req,
   output logic             valid_o,
   output logic [VEC_W-1:0] vec_o
);

   always_comb begin
      vec_o = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (src_req[i]) vec_o = VEC_W'(i + 1);
      end
   end

   assign valid_o = |src_req;

endmodule

// File: rtl/eirq_gie_ctl.sv
module eirq_gie_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic return_i,
   output logic gie_o
);

   logic gie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gie_q <= 1'b0;
      else if (take_i)   gie_q <= 1'b0;
      else if (return_i) gie_q <= 1'b1;
   end

   assign gie_o = gie_q;

endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front #(
   parameter int unsigned NUM_EXT        = 2,
   parameter int unsigned PORT_W         = 8,
   parameter bit          HAS_LEVEL_SRC  = 1'b1,
   parameter int unsigned VEC_W          = $clog2(NUM_EXT + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_EXT-1:0]   ext_pin,
   input  logic [PORT_W-1:0]    port_pins,
   input  logic [2*NUM_EXT-1:0] sense_cfg,
   input  logic [NUM_EXT-1:0]   ext_en,
   input  logic                 lvl_en,
   input  logic [NUM_EXT-1:0]   flag_clr,
   input  logic                 irq_return,
   input  logic                 ack_valid,
   input  logic [VEC_W-1:0]     ack_vec,
   output logic                 req_valid,
   output logic [VEC_W-1:0]     req_vec,
   output logic [NUM_EXT-1:0]   flags_o,
   output logic                 gie_o
);

   localparam int unsigned NSRC    = NUM_EXT + 1;
   localparam int unsigned LVL_IDX = NUM_EXT;

   generate
      if (NUM_EXT < 1) begin : g_bad_ext
         $error("ext_irq_front: NUM_EXT must be at least 1");
      end
      if (PORT_W < 1) begin : g_bad_port
         $error("ext_irq_front: PORT_W must be at least 1");
      end
      if ((1 << VEC_W) < NUM_EXT + 2) begin : g_bad_vec
         $error("ext_irq_front: VEC_W too narrow for the vector set");
      end
   endgenerate

   logic [NUM_EXT-1:0] pend;
   logic [NUM_EXT-1:0] clr_any;
   logic [NSRC-1:0]    src_req;
   logic               lvl_pend;
   logic               gie;

   generate
      for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
         assign clr_any[i] = flag_clr[i] | (ack_valid & (ack_vec == VEC_W'(i + 1)));

         eirq_sense_cell cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (ext_pin[i]),
            .sense  (sense_cfg[2*i +: 2]),
            .clr_i  (clr_any[i]),
            .flag_o (flags_o[i]),
            .pend_o (pend[i])
         );

         assign src_req[i] = pend[i] & ext_en[i] & gie;
      end
   endgenerate

   eirq_lowlevel_det #(
      .PORT_W  (PORT_W),
      .ENABLED (HAS_LEVEL_SRC)
   ) lvl_i (
      .port_pins (port_pins),
      .lvl_en    (lvl_en),
      .pend_o    (lvl_pend)
   );

   assign src_req[LVL_IDX] = lvl_pend & gie;

   eirq_prio_enc #(
      .NSRC  (NSRC),
      .VEC_W (VEC_W)
   ) prio_i (
      .src_req (src_req),
      .valid_o (req_valid),
      .vec_o   (req_vec)
   );

   eirq_gie_ctl gie_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (ack_valid),
      .return_i (irq_return),
      .gie_o    (gie)
   );

   assign gie_o = gie;

endmodule

// File: rtl/eirq_front_chk.sv
module eirq_front_chk #(
   parameter int unsigned NUM_EXT       = 2,
   parameter int unsigned PORT_W        = 8,
   parameter bit          HAS_LEVEL_SRC = 1'b1,
   parameter int unsigned VEC_W         = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_EXT-1:0]   ext_pin,
   input logic [PORT_W-1:0]    port_pins,
   input logic [2*NUM_EXT-1:0] sense_cfg,
   input logic [NUM_EXT-1:0]   ext_en,
   input logic                 lvl_en,
   input logic [NUM_EXT-1:0]   flag_clr,
   input logic                 irq_return,
   input logic                 ack_valid,
   input logic [VEC_W-1:0]     ack_vec,
   input logic                 req_valid,
   input logic [VEC_W-1:0]     req_vec,
   input logic [NUM_EXT-1:0]   flags_o,
   input logic                 gie_o
);

   logic unused_chk;
   assign unused_chk = ^ext_pin;

   a_r7_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> !gie_o);

   a_r7_return_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_return && !ack_valid) |=> gie_o);

   a_r3_gated_by_gie: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_o |-> !req_valid);

   a_r6_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_vec != '0 && int'(req_vec) <= NUM_EXT + 1));

   a_r6_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (req_vec == '0));

   generate
      if (HAS_LEVEL_SRC) begin : g_lvl
         a_r5_low_port_requests: assert property (@(posedge clk) disable iff (!rst_n)
            (gie_o && lvl_en && !(&port_pins)) |-> req_valid);
      end

      for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
         a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !flag_clr[i] && !(ack_valid && ack_vec == VEC_W'(i + 1)))
            |=> flags_o[i]);

         a_r2_level_sets_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_cfg[2*i +: 2] == 2'b00 && !flags_o[i]) |=> !flags_o[i]);

         a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && flags_o[i] && ext_en[i]) |-> (int'(req_vec) <= i + 1));
      end
   endgenerate

endmodule

bind ext_irq_front eirq_front_chk #(
   .NUM_EXT       (NUM_EXT),
   .PORT_W        (PORT_W),
   .HAS_LEVEL_SRC (HAS_LEVEL_SRC),
   .VEC_W         (VEC_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ext_pin    (ext_pin),
   .port_pins  (port_pins),
   .sense_cfg  (sense_cfg),
   .ext_en     (ext_en),
   .lvl_en     (lvl_en),
   .flag_clr   (flag_clr),
   .irq_return (irq_return),
   .ack_valid  (ack_valid),
   .ack_vec    (ack_vec),
   .req_valid  (req_valid),
   .req_vec    (req_vec),
   .flags_o    (flags_o),
   .gie_o      (gie_o)
);

// File: tb/ext_irq_front_tb_top.sv
module ext_irq_front_tb_top;

   localparam int NE = 2;
   localparam int PW = 8;
   localparam int VW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NE-1:0]   ext_pin = '0;
   logic [PW-1:0]   port_pins = '1;
   logic [2*NE-1:0] sense_cfg = '1;
   logic [NE-1:0]   ext_en = '0;
   logic            lvl_en = 1'b0;
   logic [NE-1:0]   flag_clr = '0;
   logic            irq_return = 1'b0;
   logic            ack_valid = 1'b0;
   logic [VW-1:0]   ack_vec = '0;
   logic            req_valid;
   logic [VW-1:0]   req_vec;
   logic [NE-1:0]   flags_o;
   logic            gie_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   bit [NE-1:0] m_flag   = '0;
   bit [NE-1:0] m_prev   = '0;
   bit          m_primed = 1'b0;
   bit          m_gie    = 1'b0;

   always #10 clk = ~clk;

   ext_irq_front dut_i (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pins(port_pins),
      .sense_cfg(sense_cfg), .ext_en(ext_en), .lvl_en(lvl_en),
      .flag_clr(flag_clr), .irq_return(irq_return), .ack_valid(ack_valid),
      .ack_vec(ack_vec), .req_valid(req_valid), .req_vec(req_vec),
      .flags_o(flags_o), .gie_o(gie_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // R1 edge model: modes 01 any change, 10 falling, 11 rising, 00 none
   function automatic bit edge_of(bit [1:0] m, bit p, bit c);
      case (m)
         2'b01:   return p != c;
         2'b10:   return p & !c;
         2'b11:   return !p & c;
         default: return 1'b0;
      endcase
   endfunction

   task automatic eval(input string tag);
      bit [NE:0] src;
      bit        ev;
      int        ex_vec;
      #1;
      for (int i = 0; i < NE; i++)
         src[i] = (m_flag[i] | (sense_cfg[2*i +: 2] == 2'b00 && !ext_pin[i])) & ext_en[i] & m_gie;
      src[NE] = lvl_en & m_gie & ~(&port_pins);
      ev = |src;
      ex_vec = 0;
      for (int i = NE; i >= 0; i--) if (src[i]) ex_vec = i + 1;
      check(tag, "req_valid", int'(req_valid), int'(ev));
      check(tag, "req_vec", int'(req_vec), ex_vec);
      check(tag, "flags", int'(flags_o), int'(m_flag));
      check(tag, "gie", int'(gie_o), int'(m_gie));
      @(posedge clk);
      for (int i = 0; i < NE; i++) begin
         if (m_primed && edge_of(sense_cfg[2*i +: 2], m_prev[i], ext_pin[i]))
            m_flag[i] = 1'b1;
         else if (flag_clr[i] || (ack_valid && int'(ack_vec) == i + 1))
            m_flag[i] = 1'b0;
      end
      m_prev   = ext_pin;
      m_primed = 1'b1;
      if (ack_valid)       m_gie = 1'b0;
      else if (irq_return) m_gie = 1'b1;
   endtask

   task automatic next_cycle();
      @(negedge clk);
      flag_clr   = '0;
      irq_return = 1'b0;
      ack_valid  = 1'b0;
      ack_vec    = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL R6 watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check("R7", "gie at reset", int'(gie_o), 0);
      check("R2", "flags at reset", int'(flags_o), 0);
      check("R6", "req_vec at reset", int'(req_vec), 0);
      check("R3", "req_valid at reset", int'(req_valid), 0);
      rst_n = 1'b1;

      // R1: pin high at release gives no edge on first active clock edge
      sense_cfg = 4'b1111; ext_en = 2'b11; ext_pin = 2'b01;
      eval("R1");
      next_cycle(); irq_return = 1'b1; eval("R7");
      next_cycle(); eval("R1");
      // R1 rising edge on pin 0
      next_cycle(); ext_pin = 2'b00; eval("R1");
      next_cycle(); ext_pin = 2'b01; eval("R1");
      next_cycle(); eval("R2");
      // R4 write-one-to-clear
      next_cycle(); flag_clr = 2'b01; eval("R4");
      next_cycle(); eval("R4");
      // R1 falling on pin 1, both flags, R8 priority
      next_cycle(); sense_cfg = 4'b1011; ext_pin = 2'b10; eval("R1");
      next_cycle(); ext_pin = 2'b00; eval("R1");
      next_cycle(); ext_pin = 2'b01; eval("R8");
      next_cycle(); eval("R8");
      // R4 ack of vector 1 clears flag 0 and gie; same-cycle edge beats clear
      next_cycle(); ack_valid = 1'b1; ack_vec = 2'd1; eval("R4");
      next_cycle(); eval("R3");
      next_cycle(); sense_cfg = 4'b0101; ext_pin = 2'b00; flag_clr = 2'b11; eval("R4");
      next_cycle(); eval("R4");
      // R7 ack and return together: ack wins
      next_cycle(); ack_valid = 1'b1; ack_vec = 2'd3; irq_return = 1'b1; eval("R7");
      next_cycle(); irq_return = 1'b1; eval("R7");
      // R9 level mode, no flag
      next_cycle(); flag_clr = 2'b11; sense_cfg = 4'b0000; ext_pin = 2'b11; eval("R9");
      next_cycle(); ext_pin = 2'b10; eval("R9");
      next_cycle(); eval("R9");
      next_cycle(); ext_pin = 2'b11; eval("R9");
      // R5 low port bit, vector 3
      next_cycle(); lvl_en = 1'b1; port_pins = 8'hEF; eval("R5");
      next_cycle(); ext_pin = 2'b01; eval("R8");
      next_cycle(); ext_en = 2'b00; eval("R3");
      next_cycle(); port_pins = 8'hFF; eval("R5");
      next_cycle(); lvl_en = 1'b0; port_pins = 8'h00; eval("R5");
      next_cycle(); ext_en = 2'b11; ack_valid = 1'b1; ack_vec = 2'd2; eval("R6");

      // constrained random phase
      for (int cyc = 0; cyc < 4000; cyc++) begin
         next_cycle();
         if ($urandom_range(0, 99) < 2)  sense_cfg = 4'($urandom);
         if ($urandom_range(0, 99) < 3)  ext_en    = 2'($urandom);
         if ($urandom_range(0, 99) < 3)  lvl_en    = 1'($urandom);
         if ($urandom_range(0, 3) == 0)  ext_pin   = 2'($urandom);
         port_pins = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'hFF;
         if ($urandom_range(0, 15) == 0) flag_clr = 2'($urandom);
         if ($urandom_range(0, 11) == 0) irq_return = 1'b1;
         if ($urandom_range(0, 9) == 0) begin
            ack_valid = 1'b1;
            ack_vec   = ($urandom_range(0, 1) == 0) ? req_vec : 2'($urandom);
         end
         eval("R8");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule